// File: doc/BRIEF.md
# Per-Line Receive Status Tracker

This block holds the receive-side state of a bank of serial lines: a character buffer for each line, plus a pending flag and an overrun flag. A deserializer elsewhere reports each finished character with a strobe, the line index, the data and a break marker. When a character arrives on a connected line, the block stores it and marks it pending. If a character was already pending, the block records an overrun instead. It also sends a one-cycle receive-event pulse, tagged with the line, to the interrupt scanner.

When the processor services a scanned event, it issues a read strobe with the scanned line and the event kind. The block answers one cycle later with a formatted input word. Receive-kind reads also clear the line's pending and overrun flags. Other event kinds return only the line index. While a line's connected bit is low, its flags are held clear and its arrivals are dropped.

Top module: `rx_line_status`

## Requirements
- R1: While reset is high and in the first cycle after it, `rd_valid` and `rcv_flag` are low and every line's pending and overrun flags are clear.
- R2: A character strobe on a connected line whose pending flag is clear sets pending and overwrites that line's buffer. A later receive read returns the new character with overrun 0.
- R3: A character strobe on a connected line whose pending flag is already set sets that line's overrun flag. The buffer takes the newest character.
- R4: A strobe with `rx_break` high stores 0x00 in the buffer, whatever `rx_char` carries.
- R5: Every accepted character gives `rcv_flag` high for exactly one cycle, in the cycle after the strobe, with `rcv_flag_line` equal to the line.
- R6: A read strobe gives `rd_valid` for one cycle in the next cycle. A receive read is one with `rd_kind` = 0. For such a read, `rd_word` carries the line in bits 4:0, the overrun flag in bit 15 and the buffered character in bits 23:16. Bits 14:5 are zero.
- R7: A receive read clears both the pending and overrun flags of the read line.
- R8: A read with `rd_kind` of 1, 2 or 3 returns only the line index in bits 4:0, with all other bits zero. It leaves that line's flags unchanged.
- R9: While a line's `line_conn` bit is low, its pending and overrun flags are cleared. Character strobes on it give no pulse and do not change its buffer.
- R10: When a receive read and an accepted character hit the same line in one cycle, the read returns the prior buffer and overrun. The line is then left with pending set and overrun clear.
- R11: Reads never change a line's buffer, so repeated receive reads return the same character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Character-complete strobe |
| rx_line | input | 5 | Line of the arriving character |
| rx_char | input | 8 | Arriving character |
| rx_break | input | 1 | Arrival is a break condition |
| line_conn | input | 32 | Per-line connected vector |
| rd_strobe | input | 1 | Processor input read strobe |
| rd_line | input | 5 | Line currently held by the scanner |
| rd_kind | input | 2 | Event kind of the read (0 receive, 1 transmit, 2 carrier up, 3 carrier down) |
| rd_valid | output | 1 | Input word valid |
| rd_word | output | 24 | Formatted input word |
| rcv_flag | output | 1 | Receive event pulse toward the scanner |
| rcv_flag_line | output | 5 | Line of the receive event |

## Verification
The properties assume that `rx_line` and `rd_line` are known whenever their strobes are high, and that `rx_break` is only meaningful together with `rx_valid`. The stimulus drives every input from a single task on the falling edge and holds all strobes low between operations. It never leaves an index undriven. Same-line collisions of a read and an arrival are created on purpose, in one cycle only, so that the ordering property sees both orders of state.

// File: rtl/rx_line_status_pkg.sv
package rx_line_status_pkg;

  typedef enum logic [1:0] {
    EVT_RECEIVE  = 2'd0,
    EVT_TRANSMIT = 2'd1,
    EVT_CARR_UP  = 2'd2,
    EVT_CARR_DN  = 2'd3
  } evt_kind_e;

endpackage

// File: rtl/rx_status_bank.sv
module rx_status_bank #(
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic                 clr_en,
  input  logic [LINE_W-1:0]    clr_line,
  input  logic [NUM_LINES-1:0] conn,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] ovr_q
);

  logic [NUM_LINES-1:0] wr_hit;
  logic [NUM_LINES-1:0] clr_hit;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_hit
    assign wr_hit[g]  = wr_en  && (wr_line  == LINE_W'(g));
    assign clr_hit[g] = clr_en && (clr_line == LINE_W'(g));
  end

  // Read is ordered before arrival in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ovr_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (!conn[i]) begin
          pend_q[i] <= 1'b0;
          ovr_q[i]  <= 1'b0;
        end else if (wr_hit[i]) begin
          if (clr_hit[i]) begin
            pend_q[i] <= 1'b1;
            ovr_q[i]  <= 1'b0;
          end else if (pend_q[i]) begin
            ovr_q[i]  <= 1'b1;
          end else begin
            pend_q[i] <= 1'b1;
          end
        end else if (clr_hit[i]) begin
          pend_q[i] <= 1'b0;
          ovr_q[i]  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rx_char_store.sv
module rx_char_store #(
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 5,
  parameter int CHAR_W    = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LINE_W-1:0] waddr,
  input  logic [CHAR_W-1:0] wdata,
  input  logic [LINE_W-1:0] raddr,
  output logic [CHAR_W-1:0] rdata
);

  logic [CHAR_W-1:0] mem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Synchronous read-first port.
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rx_word_fmt.sv
module rx_word_fmt
  import rx_line_status_pkg::*;
#(
  parameter int LINE_W   = 5,
  parameter int CHAR_W   = 8,
  parameter int OVR_BIT  = 15,
  parameter int CHAR_LSB = 16,
  parameter int WORD_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [1:0]        rd_kind,
  input  logic              ovr_now,
  input  logic [CHAR_W-1:0] char_rd,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word
);

  logic              valid_q;
  logic              rcv_q;
  logic              ovr_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      rcv_q   <= 1'b0;
      ovr_q   <= 1'b0;
      line_q  <= '0;
    end else begin
      valid_q <= rd_strobe;
      if (rd_strobe) begin
        rcv_q  <= (evt_kind_e'(rd_kind) == EVT_RECEIVE);
        ovr_q  <= ovr_now;
        line_q <= rd_line;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (valid_q) begin
      rd_word[LINE_W-1:0] = line_q;
      if (rcv_q) begin
        rd_word[OVR_BIT]              = ovr_q;
        rd_word[CHAR_LSB +: CHAR_W]   = char_rd;
      end
    end
  end

  assign rd_valid = valid_q;

endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rx_line_status_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int CHAR_W    = 8,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int OVR_BIT   = 15,
  parameter int CHAR_LSB  = 16,
  parameter int WORD_W    = CHAR_LSB + CHAR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [LINE_W-1:0]    rx_line,
  input  logic [CHAR_W-1:0]    rx_char,
  input  logic                 rx_break,
  input  logic [NUM_LINES-1:0] line_conn,
  input  logic                 rd_strobe,
  input  logic [LINE_W-1:0]    rd_line,
  input  logic [1:0]           rd_kind,
  output logic                 rd_valid,
  output logic [WORD_W-1:0]    rd_word,
  output logic                 rcv_flag,
  output logic [LINE_W-1:0]    rcv_flag_line
);

  logic                 rx_take;
  logic                 rd_rcv;
  logic [CHAR_W-1:0]    store_data;
  logic [CHAR_W-1:0]    char_rd;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] ovr_q;
  logic                 flag_q;
  logic [LINE_W-1:0]    flag_line_q;

  assign rx_take    = rx_valid && line_conn[rx_line];
  assign rd_rcv     = rd_strobe && (evt_kind_e'(rd_kind) == EVT_RECEIVE);
  assign store_data = rx_break ? '0 : rx_char;

  rx_status_bank #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) i_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rx_take),
    .wr_line  (rx_line),
    .clr_en   (rd_rcv),
    .clr_line (rd_line),
    .conn     (line_conn),
    .pend_q   (pend_q),
    .ovr_q    (ovr_q)
  );

  rx_char_store #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W),
    .CHAR_W    (CHAR_W)
  ) i_store (
    .clk   (clk),
    .we    (rx_take),
    .waddr (rx_line),
    .wdata (store_data),
    .raddr (rd_line),
    .rdata (char_rd)
  );

  rx_word_fmt #(
    .LINE_W   (LINE_W),
    .CHAR_W   (CHAR_W),
    .OVR_BIT  (OVR_BIT),
    .CHAR_LSB (CHAR_LSB),
    .WORD_W   (WORD_W)
  ) i_fmt (
    .clk       (clk),
    .rst       (rst),
    .rd_strobe (rd_strobe),
    .rd_line   (rd_line),
    .rd_kind   (rd_kind),
    .ovr_now   (ovr_q[rd_line]),
    .char_rd   (char_rd),
    .rd_valid  (rd_valid),
    .rd_word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q      <= 1'b0;
      flag_line_q <= '0;
    end else begin
      flag_q      <= rx_take;
      flag_line_q <= rx_line;
    end
  end

  assign rcv_flag      = flag_q;
  assign rcv_flag_line = flag_line_q;

endmodule

// File: rtl/rx_line_status_chk.sv
module rx_line_status_chk #(
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 5,
  parameter int OVR_BIT   = 15,
  parameter int WORD_W    = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_valid,
  input logic [LINE_W-1:0]    rx_line,
  input logic [NUM_LINES-1:0] line_conn,
  input logic                 rd_strobe,
  input logic [LINE_W-1:0]    rd_line,
  input logic [1:0]           rd_kind,
  input logic                 rd_valid,
  input logic [WORD_W-1:0]    rd_word,
  input logic                 rcv_flag,
  input logic [LINE_W-1:0]    rcv_flag_line,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] ovr_q
);

  logic take;
  logic rcv_rd;
  logic same;
  assign take   = rx_valid && line_conn[rx_line];
  assign rcv_rd = rd_strobe && (rd_kind == 2'd0);
  assign same   = (rx_line == rd_line);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rd_valid && !rcv_flag && (pend_q == '0) && (ovr_q == '0)));

  // R5
  flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (rcv_flag && (rcv_flag_line == $past(rx_line))));

  // R5
  flag_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid) |=> !rcv_flag);

  // R3
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (take && pend_q[rx_line] && !(rcv_rd && same)) |=> ovr_q[$past(rx_line)]);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rcv_rd && !(take && same)) |=> (!pend_q[$past(rd_line)] && !ovr_q[$past(rd_line)]));

  // R6
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_valid);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_word[OVR_BIT-1:LINE_W] == '0));

  // R8
  other_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && rd_kind != 2'd0) |=> (rd_word == WORD_W'($past(rd_line))));

  // R9
  dead_line_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !line_conn[rx_line]) |=> (!rcv_flag && !pend_q[$past(rx_line)] && !ovr_q[$past(rx_line)]));

  // R10
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    (take && rcv_rd && same) |=> (pend_q[$past(rx_line)] && !ovr_q[$past(rx_line)]));

endmodule

bind rx_line_status rx_line_status_chk #(
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W),
  .OVR_BIT   (OVR_BIT),
  .WORD_W    (WORD_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rx_valid      (rx_valid),
  .rx_line       (rx_line),
  .line_conn     (line_conn),
  .rd_strobe     (rd_strobe),
  .rd_line       (rd_line),
  .rd_kind       (rd_kind),
  .rd_valid      (rd_valid),
  .rd_word       (rd_word),
  .rcv_flag      (rcv_flag),
  .rcv_flag_line (rcv_flag_line),
  .pend_q        (pend_q),
  .ovr_q         (ovr_q)
);

// File: tb/test_rx_line_status.sv
`timescale 1ns/1ps
module test_rx_line_status;

  localparam int N  = 32;
  localparam int LW = 5;
  localparam int CW = 8;
  localparam int WW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [LW-1:0] rx_line = '0;
  logic [CW-1:0] rx_char = '0;
  logic          rx_break = 1'b0;
  logic [N-1:0]  line_conn = '1;
  logic          rd_strobe = 1'b0;
  logic [LW-1:0] rd_line = '0;
  logic [1:0]    rd_kind = '0;
  logic          rd_valid;
  logic [WW-1:0] rd_word;
  logic          rcv_flag;
  logic [LW-1:0] rcv_flag_line;

  always #2 clk = ~clk;

  rx_line_status i_rx_line_status (
    .clk (clk), .rst (rst), .rx_valid (rx_valid), .rx_line (rx_line),
    .rx_char (rx_char), .rx_break (rx_break), .line_conn (line_conn),
    .rd_strobe (rd_strobe), .rd_line (rd_line), .rd_kind (rd_kind),
    .rd_valid (rd_valid), .rd_word (rd_word), .rcv_flag (rcv_flag),
    .rcv_flag_line (rcv_flag_line)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference state
  logic [CW-1:0] m_buf [N];
  logic [N-1:0]  m_pend = '0;
  logic [N-1:0]  m_ovr  = '0;

  logic [WW-1:0] exp_word_q [$];
  string         exp_word_tag [$];
  logic [LW-1:0] exp_flag_q [$];

  task automatic report(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle of stimulus; pushes expectations from the requirements
  task automatic step(input bit rxv, input int rxl, input logic [7:0] c, input bit brk,
                      input bit rds, input int rdl, input int kind, input string tag);
    rx_valid  = rxv;  rx_line = LW'(rxl); rx_char = c; rx_break = brk;
    rd_strobe = rds;  rd_line = LW'(rdl); rd_kind = 2'(kind);
    if (rds) begin
      if (kind == 0) begin
        exp_word_q.push_back({m_buf[rdl], m_ovr[rdl], 10'b0, 5'(rdl)});
        m_pend[rdl] = 1'b0;
        m_ovr[rdl]  = 1'b0;
      end else begin
        exp_word_q.push_back(WW'(rdl));
      end
      exp_word_tag.push_back(tag);
    end
    if (rxv && line_conn[rxl]) begin
      exp_flag_q.push_back(LW'(rxl));
      m_buf[rxl] = brk ? 8'h00 : c;
      if (m_pend[rxl]) m_ovr[rxl] = 1'b1;
      else m_pend[rxl] = 1'b1;
    end
    m_pend = m_pend & line_conn;
    m_ovr  = m_ovr & line_conn;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rd_strobe = 1'b0; rx_break = 1'b0;
  endtask

  task automatic rx(input int l, input logic [7:0] c, input string tag);
    step(1, l, c, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int l, input int kind, input string tag);
    step(0, 0, 8'h00, 0, 1, l, kind, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_valid) begin
        if (exp_word_q.size() == 0) begin
          report("R6 unexpected word", rd_word, '0);
        end else begin
          report(exp_word_tag.pop_front(), rd_word, exp_word_q.pop_front());
        end
      end
      if (rcv_flag) begin
        if (exp_flag_q.size() == 0) begin
          report("R9 unexpected pulse", WW'(rcv_flag_line), '1);
        end else begin
          report("R5 pulse line", WW'(rcv_flag_line), WW'(exp_flag_q.pop_front()));
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    report("R1 rd_valid in reset", WW'(rd_valid), '0);
    report("R1 rcv_flag in reset", WW'(rcv_flag), '0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    report("R1 rd_valid after reset", WW'(rd_valid), '0);

    // R2 fill all lines, read back
    for (int l = 0; l < N; l++) rx(l, 8'(l ^ 8'h80), "R2");
    for (int l = 0; l < N; l++) rd(l, 0, "R2 fresh char");

    // R3 overrun, R11 repeated read
    rx(7, 8'h3C, "R3");
    rx(7, 8'h4D, "R3");
    rd(7, 0, "R3 overrun read");
    rd(7, 0, "R7 cleared / R11 same char");
    rx(7, 8'h4E, "R7");
    rd(7, 0, "R7 no overrun after clear");

    // R4 break
    rx(9, 8'h55, "R4");
    rd(9, 0, "R4 setup");
    step(1, 9, 8'hFF, 1, 0, 0, 0, "R4");
    rd(9, 0, "R4 break zero");

    // R8 other kinds keep status
    rx(12, 8'hA1, "R8");
    rx(12, 8'hA2, "R8");
    rd(12, 2, "R8 kind2 line only");
    rd(12, 1, "R8 kind1 line only");
    rd(31, 3, "R8 kind3 line only");
    rd(12, 0, "R8 overrun kept");

    // R10 same-line collision
    rx(20, 8'h11, "R10");
    step(1, 20, 8'h22, 0, 1, 20, 0, "R10 collide read");
    rd(20, 0, "R10 left pending no overrun");
    rx(20, 8'h33, "R10");
    step(1, 20, 8'h44, 0, 1, 20, 0, "R10 collide old overrun");
    rx(20, 8'h66, "R10");
    rd(20, 0, "R10 pending after collide");

    // R9 disconnect
    rx(25, 8'h01, "R9");
    rx(25, 8'h02, "R9");
    line_conn[25] = 1'b0;
    rx(25, 8'h77, "R9 dropped");
    line_conn[25] = 1'b1;
    rd(25, 0, "R9 cleared buffer kept");

    // boundary lines 0 and 31
    rx(0, 8'hE0, "R2");
    rx(31, 8'hE1, "R2");
    rx(31, 8'hE2, "R3");
    rd(0, 0, "R2 line 0");
    rd(31, 0, "R3 line 31");

    repeat (4) @(negedge clk);
    report("R6 words outstanding", WW'(exp_word_q.size()), '0);
    report("R5 pulses outstanding", WW'(exp_flag_q.size()), '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule